// File: doc/BRIEF.md
# Flash Block-Lock and Write-State Controller

This controller guards a 1 MB byte-wide flash array divided into sixteen 64 KB blocks. It takes already-decoded commands with a target address and checks each one against two levels of protection:

- A per-block lock bit protects the contents of each block.
- A single master lock bit protects the per-block bits themselves.

A permitted operation runs a timed busy phase. Byte writes, block erases and lock-bit changes are each modelled as a fixed number of clock cycles. A refused command never becomes busy. It only leaves sticky error flags in the status byte.

The controller supports two kinds of suspend. An erase may be suspended, and a byte write may then run to a different block. A byte write may also be suspended on its own. An active-low power-down input aborts any operation, blanks the status byte and blocks commands. After the input is released, commands stay blocked for a wake delay.

The `ready_busy` pin is low only while an operation is actually running. It is high when the controller is idle, in either suspend state, in power-down and during the wake delay. Status bit 7 is narrower: it is 1 only when the controller will accept a command.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The target block is `cmd_addr[19:16]`. A block erase or byte write to a block whose lock bit is set is refused: `ready_busy` stays high. Status bit 1 is set, together with bit 5 for an erase or bit 4 for a write. Any address in the range 0xN0000..0xNFFFF belongs to block N.
- R2: While the master lock bit is set, set-block-lock is refused and sets status bits 4 and 1. Clear-all-block-locks is refused and sets bits 5 and 1. Refused commands leave the per-block bits unchanged.
- R3: Each lock-bit command, when accepted, busies the controller for `LOCK_CYC` cycles and then takes effect:
  - set-block-lock sets the bit of the addressed block;
  - clear-all-block-locks clears all sixteen bits in one operation;
  - set-master-lock sets the master bit, which only `rst_n` clears.
- R4: An accepted byte write holds `ready_busy` low for exactly `WRITE_CYC` cycles and a block erase for `ERASE_CYC` cycles. Status bit 7 reads 0 throughout and returns to 1 afterwards.
- R5: Suspend during a running erase takes effect at the next edge. `ready_busy` then goes high and status reads bits 7 and 6. Resume continues the erase for its remaining cycles, so the total busy time equals `ERASE_CYC`.
- R6: While an erase is suspended, a byte write to another unlocked block runs for `WRITE_CYC` cycles with status bit 6 kept, then returns to the suspended state. A write to the suspended block is refused with status bit 4 only.
- R7: Suspend during a byte write makes `ready_busy` high with status bits 7 and 2. Resume completes the remaining cycles.
- R8: Every command other than suspend is ignored while an operation is busy. While a write is suspended, only resume and clear-status are acted on.
- R9: Status bits 5, 4 and 1 are sticky: later successful operations leave them set. Clear-status (code 0) clears them when the controller is ready.
- R10: `pd_n` low aborts any operation and clears the error bits. From the next edge, status reads 0x00 and `ready_busy` reads high. Commands are ignored while `pd_n` is low. Lock bits are retained.
- R11: The first edge that sees `pd_n` high starts a wake delay. Commands sampled at that edge and the next `WAKE_CYC` edges are ignored, and status reads 0x00 throughout. After that, status reads 0x80 and commands are accepted.
- R12: After `rst_n`, every lock bit including the master is clear, status reads 0x80 and `ready_busy` is high.
- R13: Command codes on `cmd_op` are:

  | Code | Command |
  |------|---------|
  | 0 | clear-status |
  | 1 | erase |
  | 2 | write |
  | 3 | set-block-lock |
  | 4 | set-master-lock |
  | 5 | clear-all-block-locks |
  | 6 | suspend |
  | 7 | resume |

  A code is acted on only at an edge where `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pd_n | input | 1 | Active-low power-down, sampled on the clock |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (R13) |
| cmd_addr | input | 20 | Target byte address; bits 19:16 select the block |
| ready_busy | output | 1 | Low while an operation is running |
| status | output | 8 | Status byte: 7 ready, 6 erase suspended, 5 erase error, 4 write error, 2 write suspended, 1 lock violation |

## Verification
Power-down and a running operation can fall on the same edge. The bench drops `pd_n` mid-erase and expects status 0x00 with `ready_busy` high one cycle later, with no erase completion afterwards. A command and a lock-check or wake decision can also coincide. The bench holds an erase strobe continuously across the whole wake window, and also issues an erase in the cycle right after a write starts. It then confirms at the ports that the controller stays idle or that the write's duration is unchanged.

// File: rtl/flc_pkg.sv
package flc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE,
    ST_WRITE,
    ST_LOCK,
    ST_ESUSP,
    ST_ESW,
    ST_WSUSP,
    ST_PDOWN,
    ST_WAKE
  } flc_state_e;

  typedef enum logic [2:0] {
    OP_CLRSTAT = 3'd0,
    OP_ERASE   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_SETBLK  = 3'd3,
    OP_SETMST  = 3'd4,
    OP_CLRBLK  = 3'd5,
    OP_SUSPEND = 3'd6,
    OP_RESUME  = 3'd7
  } flc_op_e;

  typedef enum logic [1:0] {
    PL_NONE,
    PL_SETBLK,
    PL_SETMST,
    PL_CLRALL
  } flc_pend_e;

  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_EERR  = 5;
  localparam int SB_WERR  = 4;
  localparam int SB_WSUSP = 2;
  localparam int SB_LOCKV = 1;

endpackage

// File: rtl/flc_timer.sv
module flc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/flc_lock_bank.sv
module flc_lock_bank #(
  parameter  int NBLK = 16,
  localparam int BW   = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_blk,
  input  logic [BW-1:0]   set_idx,
  input  logic            clr_all,
  input  logic            set_mst,
  output logic [NBLK-1:0] locked,
  output logic            master
);

  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_en;

    always_comb begin
      bit_en = clr_all | (set_blk && (set_idx == BW'(b)));
      bit_d  = !clr_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign locked[b] = bit_q;
  end

  logic mst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= 1'b0;
    end else if (set_mst) begin
      mst_q <= 1'b1;
    end
  end

  assign master = mst_q;

endmodule

// File: rtl/flc_sticky.sv
module flc_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_eerr,
  input  logic set_werr,
  input  logic set_lv,
  output logic eerr,
  output logic werr,
  output logic lv
);

  logic [2:0] flg_q;
  logic [2:0] flg_d;
  logic       flg_en;

  always_comb begin
    flg_en = clr | set_eerr | set_werr | set_lv;
    if (clr) begin
      flg_d = 3'b000;
    end else begin
      flg_d = flg_q | {set_eerr, set_werr, set_lv};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= 3'b000;
    end else if (flg_en) begin
      flg_q <= flg_d;
    end
  end

  assign eerr = flg_q[2];
  assign werr = flg_q[1];
  assign lv   = flg_q[0];

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flc_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NBLK      = 16,
  parameter int WRITE_CYC = 6,
  parameter int ERASE_CYC = 200,
  parameter int LOCK_CYC  = 8,
  parameter int WAKE_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              ready_busy,
  output logic [7:0]        status
);

  localparam int BW     = $clog2(NBLK);
  localparam int MAX_WL = (WRITE_CYC > LOCK_CYC) ? WRITE_CYC : LOCK_CYC;
  localparam int MAX_OP = (MAX_WL > WAKE_CYC) ? MAX_WL : WAKE_CYC;
  localparam int OCW    = $clog2(MAX_OP + 1);
  localparam int ECW    = $clog2(ERASE_CYC + 1);

  localparam logic [OCW-1:0] W_LOAD  = OCW'(WRITE_CYC - 1);
  localparam logic [OCW-1:0] L_LOAD  = OCW'(LOCK_CYC - 1);
  localparam logic [OCW-1:0] WK_LOAD = OCW'(WAKE_CYC - 1);
  localparam logic [ECW-1:0] E_LOAD  = ECW'(ERASE_CYC - 1);

  flc_state_e st_q, st_d;
  flc_pend_e  pend_q, pend_d;
  logic [BW-1:0] pblk_q, pblk_d;
  logic [BW-1:0] eblk_q, eblk_d;
  logic          aux_en;

  flc_op_e       op;
  logic [BW-1:0] blk;
  logic          unused_addr_bits;

  assign op  = flc_op_e'(cmd_op);
  assign blk = cmd_addr[ADDR_W-1 -: BW];
  assign unused_addr_bits = ^cmd_addr[ADDR_W-BW-1:0];

  logic            op_load, op_dec, op_zero;
  logic [OCW-1:0]  op_val;
  logic            er_load, er_dec, er_zero;

  logic [NBLK-1:0] locked;
  logic            master;
  logic            lk_set_blk, lk_set_mst, lk_clr;

  logic            sr_clr, sr_eerr, sr_werr, sr_lv;
  logic            f_eerr, f_werr, f_lv;

  logic            is_susp;
  assign is_susp = cmd_valid && (op == OP_SUSPEND);

  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    pblk_d     = pblk_q;
    eblk_d     = eblk_q;
    aux_en     = 1'b0;
    op_load    = 1'b0;
    op_val     = W_LOAD;
    op_dec     = 1'b0;
    er_load    = 1'b0;
    er_dec     = 1'b0;
    lk_set_blk = 1'b0;
    lk_set_mst = 1'b0;
    lk_clr     = 1'b0;
    sr_clr     = 1'b0;
    sr_eerr    = 1'b0;
    sr_werr    = 1'b0;
    sr_lv      = 1'b0;

    if (!pd_n) begin
      st_d   = ST_PDOWN;
      sr_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_PDOWN: begin
          st_d    = ST_WAKE;
          op_load = 1'b1;
          op_val  = WK_LOAD;
        end

        ST_WAKE: begin
          if (op_zero) st_d = ST_IDLE;
          else         op_dec = 1'b1;
        end

        ST_IDLE: begin
          if (cmd_valid) begin
            unique case (op)
              OP_CLRSTAT: sr_clr = 1'b1;
              OP_ERASE: begin
                if (locked[blk]) begin
                  sr_eerr = 1'b1;
                  sr_lv   = 1'b1;
                end else begin
                  st_d    = ST_ERASE;
                  er_load = 1'b1;
                  eblk_d  = blk;
                  aux_en  = 1'b1;
                end
              end
              OP_WRITE: begin
                if (locked[blk]) begin
                  sr_werr = 1'b1;
                  sr_lv   = 1'b1;
                end else begin
                  st_d    = ST_WRITE;
                  op_load = 1'b1;
                end
              end
              OP_SETBLK: begin
                if (master) begin
                  sr_werr = 1'b1;
                  sr_lv   = 1'b1;
                end else begin
                  st_d    = ST_LOCK;
                  op_load = 1'b1;
                  op_val  = L_LOAD;
                  pend_d  = PL_SETBLK;
                  pblk_d  = blk;
                  aux_en  = 1'b1;
                end
              end
              OP_SETMST: begin
                st_d    = ST_LOCK;
                op_load = 1'b1;
                op_val  = L_LOAD;
                pend_d  = PL_SETMST;
                aux_en  = 1'b1;
              end
              OP_CLRBLK: begin
                if (master) begin
                  sr_eerr = 1'b1;
                  sr_lv   = 1'b1;
                end else begin
                  st_d    = ST_LOCK;
                  op_load = 1'b1;
                  op_val  = L_LOAD;
                  pend_d  = PL_CLRALL;
                  aux_en  = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end

        ST_ERASE: begin
          if (er_zero) begin
            st_d = ST_IDLE;
          end else begin
            er_dec = 1'b1;
            if (is_susp) st_d = ST_ESUSP;
          end
        end

        ST_WRITE: begin
          if (op_zero) begin
            st_d = ST_IDLE;
          end else begin
            op_dec = 1'b1;
            if (is_susp) st_d = ST_WSUSP;
          end
        end

        ST_LOCK: begin
          if (op_zero) begin
            st_d = ST_IDLE;
            unique case (pend_q)
              PL_SETBLK: lk_set_blk = 1'b1;
              PL_SETMST: lk_set_mst = 1'b1;
              PL_CLRALL: lk_clr     = 1'b1;
              default: ;
            endcase
          end else begin
            op_dec = 1'b1;
          end
        end

        ST_ESUSP: begin
          if (cmd_valid) begin
            unique case (op)
              OP_CLRSTAT: sr_clr = 1'b1;
              OP_RESUME:  st_d   = ST_ERASE;
              OP_WRITE: begin
                if (blk == eblk_q) begin
                  sr_werr = 1'b1;
                end else if (locked[blk]) begin
                  sr_werr = 1'b1;
                  sr_lv   = 1'b1;
                end else begin
                  st_d    = ST_ESW;
                  op_load = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end

        ST_ESW: begin
          if (op_zero) st_d = ST_ESUSP;
          else         op_dec = 1'b1;
        end

        ST_WSUSP: begin
          if (cmd_valid) begin
            unique case (op)
              OP_CLRSTAT: sr_clr = 1'b1;
              OP_RESUME:  st_d   = ST_WRITE;
              default: ;
            endcase
          end
        end

        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PL_NONE;
      pblk_q <= '0;
      eblk_q <= '0;
    end else if (aux_en) begin
      pend_q <= pend_d;
      pblk_q <= pblk_d;
      eblk_q <= eblk_d;
    end
  end

  flc_timer #(.CW(OCW)) u_op_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (op_load),
    .load_val (op_val),
    .dec      (op_dec),
    .zero     (op_zero)
  );

  flc_timer #(.CW(ECW)) u_erase_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (er_load),
    .load_val (E_LOAD),
    .dec      (er_dec),
    .zero     (er_zero)
  );

  flc_lock_bank #(.NBLK(NBLK)) u_locks (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_blk (lk_set_blk),
    .set_idx (pblk_q),
    .clr_all (lk_clr),
    .set_mst (lk_set_mst),
    .locked  (locked),
    .master  (master)
  );

  flc_sticky u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sr_clr),
    .set_eerr (sr_eerr),
    .set_werr (sr_werr),
    .set_lv   (sr_lv),
    .eerr     (f_eerr),
    .werr     (f_werr),
    .lv       (f_lv)
  );

  always_comb begin
    ready_busy = !(st_q == ST_ERASE || st_q == ST_WRITE ||
                   st_q == ST_LOCK  || st_q == ST_ESW);
    status           = 8'h00;
    status[SB_READY] = (st_q == ST_IDLE) || (st_q == ST_ESUSP) || (st_q == ST_WSUSP);
    status[SB_ESUSP] = (st_q == ST_ESUSP) || (st_q == ST_ESW);
    status[SB_EERR]  = f_eerr;
    status[SB_WERR]  = f_werr;
    status[SB_WSUSP] = (st_q == ST_WSUSP);
    status[SB_LOCKV] = f_lv;
  end

endmodule

// File: rtl/flc_checker.sv
module flc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pd_n,
  input logic       ready_busy,
  input logic [7:0] status
);

  // R1: a lock refusal never starts a busy phase
  p_reject_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> ready_busy);

  // R2: a lock violation always comes with an erase or write error
  p_lv_paired_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> (status[5] || status[4]));

  // R4: the ready bit reads 0 whenever the pin shows busy
  p_busy_notready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_busy |-> !status[7]);

  // R7: a suspended write shows ready on the pin
  p_wsusp_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> ready_busy);

  // R10: power-down blanks status and raises the pin
  p_pd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (status == 8'h00 && ready_busy));

endmodule

bind flash_lock_ctrl flc_checker u_flc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_n       (pd_n),
  .ready_busy (ready_busy),
  .status     (status)
);

// File: tb/flash_lock_ctrl_bench.sv
module flash_lock_ctrl_bench;

  localparam int W  = 4;
  localparam int E  = 12;
  localparam int L  = 3;
  localparam int WK = 5;

  localparam logic [2:0] C_CLR = 3'd0, C_ERASE = 3'd1, C_WRITE = 3'd2, C_SETB = 3'd3,
                         C_SETM = 3'd4, C_CLRB = 3'd5, C_SUSP = 3'd6, C_RES = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n, pd_n, cmd_valid;
  logic [2:0]  cmd_op;
  logic [19:0] cmd_addr;
  logic        ready_busy;
  logic [7:0]  status;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_lock_ctrl #(.WRITE_CYC(W), .ERASE_CYC(E), .LOCK_CYC(L), .WAKE_CYC(WK))
    u_flash_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .ready_busy(ready_busy), .status(status));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [19:0] addr);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic hold_busy(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, {7'd0, ready_busy}, 8'h00);
      if (i < n - 1) step();
    end
  endtask

  task automatic busy_for(input int n, input string req);
    hold_busy(n, req);
    step();
    chk(req, {7'd0, ready_busy}, 8'h01);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pd_n = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R12 reset status", status, 8'h80);
    chk("R12 reset pin", {7'd0, ready_busy}, 8'h01);
  endtask

  task automatic t_timing();
    issue(C_WRITE, 20'h2_0010);
    chk("R4 write busy status", status, 8'h00);
    busy_for(W, "R4 write duration");
    issue(C_ERASE, 20'h3_0000);
    busy_for(E, "R4 erase duration");
    chk("R4 ready after erase", status, 8'h80);
    cmd_op = C_ERASE; cmd_addr = 20'h3_0000; cmd_valid = 1'b0;
    step();
    chk("R13 no valid no action", {7'd0, ready_busy}, 8'h01);
  endtask

  task automatic t_locks();
    issue(C_SETB, 20'h5_1234);
    busy_for(L, "R3 set block lock duration");
    issue(C_ERASE, 20'h5_FFFF);
    chk("R1 erase refused pin", {7'd0, ready_busy}, 8'h01);
    chk("R1 erase refused status", status, 8'hA2);
    issue(C_WRITE, 20'h4_FFFF);
    busy_for(W, "R1 neighbour block 4 unlocked");
    chk("R9 sticky after good write", status, 8'hA2);
    issue(C_CLR, 20'h0);
    chk("R9 clear status", status, 8'h80);
    issue(C_WRITE, 20'h5_0000);
    chk("R1 write refused status", status, 8'h92);
    issue(C_CLR, 20'h0);
    issue(C_SETB, 20'h9_0000);
    busy_for(L, "R3 set block 9");
    issue(C_CLRB, 20'h0);
    busy_for(L, "R3 clear all duration");
    issue(C_WRITE, 20'h5_0000);
    busy_for(W, "R3 block 5 cleared");
    issue(C_WRITE, 20'h9_8000);
    busy_for(W, "R3 block 9 cleared");
    chk("R3 no error after clear", status, 8'h80);
  endtask

  task automatic t_master();
    issue(C_SETB, 20'hA_0000);
    busy_for(L, "R2 lock block A");
    issue(C_SETM, 20'h0);
    busy_for(L, "R3 set master duration");
    issue(C_SETB, 20'h3_0000);
    chk("R2 set block refused pin", {7'd0, ready_busy}, 8'h01);
    chk("R2 set block refused", status, 8'h92);
    issue(C_CLR, 20'h0);
    issue(C_CLRB, 20'h0);
    chk("R2 clear all refused", status, 8'hA2);
    issue(C_CLR, 20'h0);
    issue(C_WRITE, 20'hA_0001);
    chk("R2 block A still locked", status, 8'h92);
    issue(C_ERASE, 20'h3_0000);
    busy_for(E, "R2 block 3 unchanged");
    issue(C_CLR, 20'h0);
  endtask

  task automatic t_esusp();
    issue(C_ERASE, 20'h1_0000);
    hold_busy(3, "R5 erase before suspend");
    issue(C_SUSP, 20'h0);
    chk("R5 suspended pin", {7'd0, ready_busy}, 8'h01);
    chk("R5 suspended status", status, 8'hC0);
    issue(C_WRITE, 20'h1_0040);
    chk("R6 same block refused", status, 8'hD0);
    issue(C_CLR, 20'h0);
    chk("R6 clear in suspend", status, 8'hC0);
    issue(C_WRITE, 20'h2_0040);
    chk("R6 write in suspend status", status, 8'h40);
    busy_for(W, "R6 write in suspend duration");
    chk("R6 back to suspend", status, 8'hC0);
    issue(C_RES, 20'h0);
    busy_for(E - 3, "R5 resume remaining");
    chk("R5 erase done", status, 8'h80);
  endtask

  task automatic t_wsusp();
    issue(C_WRITE, 20'h6_0000);
    hold_busy(2, "R7 write before suspend");
    issue(C_SUSP, 20'h0);
    chk("R7 write suspended", status, 8'h84);
    chk("R7 pin high", {7'd0, ready_busy}, 8'h01);
    issue(C_ERASE, 20'h7_0000);
    chk("R8 erase ignored in write suspend", status, 8'h84);
    issue(C_RES, 20'h0);
    busy_for(W - 2, "R7 resume remaining");
    chk("R7 done", status, 8'h80);
  endtask

  task automatic t_busy_ignore();
    issue(C_WRITE, 20'h7_0000);
    issue(C_ERASE, 20'h7_0000);
    hold_busy(W - 1, "R8 write unaffected");
    step();
    chk("R8 no erase started", {7'd0, ready_busy}, 8'h01);
    step();
    chk("R8 still idle", status, 8'h80);
  endtask

  task automatic t_pdown();
    issue(C_ERASE, 20'h8_0000);
    pd_n = 1'b0;
    step();
    chk("R10 pd status", status, 8'h00);
    chk("R10 pd pin", {7'd0, ready_busy}, 8'h01);
    issue(C_ERASE, 20'h8_0000);
    chk("R10 command ignored in pd", {7'd0, ready_busy}, 8'h01);
    pd_n = 1'b1;
    cmd_valid = 1'b1; cmd_op = C_ERASE; cmd_addr = 20'h8_0000;
    for (int i = 0; i < WK; i++) begin
      step();
      chk("R11 wake status", status, 8'h00);
      chk("R11 wake ignores", {7'd0, ready_busy}, 8'h01);
    end
    step();
    cmd_valid = 1'b0;
    chk("R11 wake over status", status, 8'h80);
    chk("R11 last wake edge ignored", {7'd0, ready_busy}, 8'h01);
    issue(C_ERASE, 20'h8_0000);
    busy_for(E, "R11 accepted after wake");
    issue(C_WRITE, 20'hA_0000);
    chk("R10 locks retained", status, 8'h92);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_locks();
    t_master();
    t_esusp();
    t_wsusp();
    t_busy_ignore();
    t_pdown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule